// File: doc/BRIEF.md
# Fill-Once Entropy Observe Buffer

This block takes a stream of health-tested entropy words and keeps a copy of one contiguous window of them, so that firmware can read that window through a register-style read port. Each word on the input stream is also sent on, unchanged and in the same cycle, to the downstream hardware pipeline. Observation never holds back the stream.

Capture runs only when two values both hold the multi-bit true code. The first is an 8-bit enable from one-time-programmable storage (true is 8'h96). The second is a 4-bit mode field (true is 4'h6, false is 4'h9). When capture is on, words go into a 64-entry buffer of 32-bit words, which holds 2048 bits. When the 64th word is written, the buffer freezes. From then on it drops every arriving word and raises an overflow alert for each drop. It does not start capturing again until firmware has popped every entry. Popping only some of the entries is not enough.

Firmware sees the oldest held word on the read data port and pops it with a one-cycle strobe. The block reports when the buffer is full and when it is empty. It also reports a mode field that holds neither valid code.

Top module: `entropy_observe_buf`

## Requirements
- R1: After reset the buffer is empty (`obs_empty`=1, `obs_full`=0), `rd_word` is zero and `ovf_alert` is 0.
- R2: A word with `in_valid`=1 is captured only when `otp_ovr_en`==8'h96 and `obs_mode`==4'h6. With any other value of either input, no word is stored and the empty/full status does not change.
- R3: `pass_valid` and `pass_word` equal `in_valid` and `in_word` in the same cycle, whatever the enable and mode inputs hold.
- R4: Captured words are read in arrival order. `rd_word` shows the oldest held word, and `rd_pop`=1 removes it at the clock edge.
- R5: The buffer holds 64 words. `obs_full` is 1 exactly when 64 words are held, and `obs_empty` is 1 exactly when none are held.
- R6: A word that arrives while capture is enabled but the buffer is frozen is discarded, and `ovf_alert` is 1 for one cycle, in the cycle after that word.
- R7: Once 64 words have been captured, no word is captured until a pop leaves the buffer empty, even after partial pops. A word that arrives in the same cycle as that last pop is dropped and flagged. The cycle after the last pop is the first one that can capture.
- R8: While the buffer is empty, `rd_word` is zero and `rd_pop` has no effect.
- R9: `mode_enc_err` is 1, in the same cycle, whenever `obs_mode` is neither 4'h6 nor 4'h9. Such a value is treated as false.
- R10: While not frozen, a capture and a pop in the same cycle are both carried out, and the held count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| otp_ovr_en | input | 8 | OTP override enable, 8'h96 = true |
| obs_mode | input | 4 | Observe mode, 4'h6 = true, 4'h9 = false |
| in_valid | input | 1 | Input entropy word valid |
| in_word | input | 32 | Input entropy word |
| pass_valid | output | 1 | Valid forwarded downstream |
| pass_word | output | 32 | Word forwarded downstream |
| rd_pop | input | 1 | Pop strobe for the read data register |
| rd_word | output | 32 | Oldest held word, zero when empty |
| obs_full | output | 1 | 64 words held |
| obs_empty | output | 1 | No word held |
| ovf_alert | output | 1 | One-cycle pulse after a dropped word |
| mode_enc_err | output | 1 | Mode field holds an invalid code |

## Verification
The capture path and the firmware pop can act in the same cycle. This matters most when the pop removes the last entry of a frozen buffer while a new word arrives: that word must be dropped and flagged, and a word in the very next cycle must be captured. The bench builds this case directly and also gets it from random valid and pop patterns. A reference queue computed in the bench judges every cycle. The same random traffic also covers a push and a pop together on a buffer that is not frozen, where the bench expects the held count to stay the same and the order to be kept.

// File: rtl/obs_pkg.sv
// Package: shared multi-bit encodings and sizes for the entropy observe buffer.
// Assumes a true/false pair of codes; every other code is treated as false.
package obs_pkg;
    localparam logic [3:0] MB4_TRUE  = 4'h6;
    localparam logic [3:0] MB4_FALSE = 4'h9;
    localparam logic [7:0] MB8_TRUE  = 8'h96;

    // Returns 1 when a 4-bit field holds one of the two legal codes.
    function automatic logic mb4_legal(input logic [3:0] v);
        return (v == MB4_TRUE) || (v == MB4_FALSE);
    endfunction
endpackage

// File: rtl/obs_enable_gate.sv
// Module: obs_enable_gate
// Decodes the OTP enable and the mode field into one capture enable and flags
// a mode field that holds an illegal code. Purely combinational.
// Assumes both inputs are stable within a cycle (no synchronisation here).
module obs_enable_gate
    import obs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] otp_en,
    input  logic [3:0] mode,
    output logic       cap_en,
    output logic       enc_err
);
    // Capture only when both multi-bit fields hold exactly their true code.
    always_comb begin
        cap_en  = (otp_en == MB8_TRUE) && (mode == MB4_TRUE);
        enc_err = !mb4_legal(mode);
    end

    // An enabled capture never coincides with an encoding error.
    AST_EN_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> !enc_err); // R9
endmodule

// File: rtl/obs_fill_store.sv
// Module: obs_fill_store
// Fill-once word store. It takes words until DEPTH are held, then freezes and
// refuses writes until a pop leaves it empty. Drops are reported one cycle
// later. Reads are combinational from the head and give zero when empty.
// Assumes wr_req is already qualified by the capture enable.
module obs_fill_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty,
    output logic [$clog2(DEPTH):0] count,
    output logic             ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             frozen_q, frozen_d;
    logic             do_wr, do_rd, drop;

    // Decide which requests take effect this cycle.
    always_comb begin
        empty = (cnt_q == '0);
        full  = (cnt_q == CNT_MAX);
        do_wr = wr_req && !frozen_q && !full;
        drop  = wr_req && !do_wr;
        do_rd = pop && !empty;
    end

    // Next count and next freeze state.
    always_comb begin
        cnt_d = cnt_q;
        if (do_wr && !do_rd)      cnt_d = cnt_q + 1'b1;
        else if (!do_wr && do_rd) cnt_d = cnt_q - 1'b1;
        frozen_d = frozen_q;
        if (do_wr && cnt_d == CNT_MAX)   frozen_d = 1'b1;
        else if (do_rd && cnt_d == '0)   frozen_d = 1'b0;
    end

    // Pointer, count, freeze and overflow-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt_q    <= '0;
            frozen_q <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            cnt_q    <= cnt_d;
            frozen_q <= frozen_d;
            ovf      <= drop;
        end
    end

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Head read, forced to zero while empty.
    always_comb begin
        rd_data = empty ? '0 : mem[rd_ptr];
        count   = cnt_q;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX); // R5
    AST_FROZEN_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        frozen_q |=> (cnt_q <= $past(cnt_q))); // R7
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_req) |=> (cnt_q == '0)); // R8
    AST_DROP_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (cnt_q <= $past(cnt_q))); // R6
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && do_rd) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/entropy_observe_buf.sv
// Module: entropy_observe_buf
// Top of the fill-once entropy observe buffer. It forwards the input stream
// unchanged and copies qualified words into the fill-once store for firmware.
// Assumes rd_pop is a one-cycle strobe from the register decode.
module entropy_observe_buf #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       otp_ovr_en,
    input  logic [3:0]       obs_mode,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_word,
    output logic             pass_valid,
    output logic [WIDTH-1:0] pass_word,
    input  logic             rd_pop,
    output logic [WIDTH-1:0] rd_word,
    output logic             obs_full,
    output logic             obs_empty,
    output logic             ovf_alert,
    output logic             mode_enc_err
);
    logic                  cap_en;
    logic [$clog2(DEPTH):0] held;

    obs_enable_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .otp_en  (otp_ovr_en),
        .mode    (obs_mode),
        .cap_en  (cap_en),
        .enc_err (mode_enc_err)
    );

    obs_fill_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (in_valid && cap_en),
        .wr_data (in_word),
        .pop     (rd_pop),
        .rd_data (rd_word),
        .full    (obs_full),
        .empty   (obs_empty),
        .count   (held),
        .ovf     (ovf_alert)
    );

    // Observe-only: the hardware pipeline sees every word untouched.
    always_comb begin
        pass_valid = in_valid;
        pass_word  = in_word;
    end

    AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !rd_pop) |=> $stable(held)); // R2
    AST_OVF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_alert |-> $past(cap_en && in_valid)); // R6
endmodule

// File: tb/tb_entropy_observe_buf.sv
// Bench: random plus directed traffic against a reference queue.
module tb_entropy_observe_buf;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  otp_ovr_en = 8'h00;
    logic [3:0]  obs_mode = 4'h9;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        rd_pop = 1'b0;
    logic        pass_valid, obs_full, obs_empty, ovf_alert, mode_enc_err;
    logic [31:0] pass_word, rd_word;

    int checks = 0;
    int fails = 0;
    logic [31:0] q [$];
    bit frozen = 0;
    bit exp_ovf = 0;

    always #10 clk = ~clk;

    entropy_observe_buf dut (
        .clk(clk), .rst_n(rst_n), .otp_ovr_en(otp_ovr_en), .obs_mode(obs_mode),
        .in_valid(in_valid), .in_word(in_word), .pass_valid(pass_valid),
        .pass_word(pass_word), .rd_pop(rd_pop), .rd_word(rd_word),
        .obs_full(obs_full), .obs_empty(obs_empty), .ovf_alert(ovf_alert),
        .mode_enc_err(mode_enc_err)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit cap_on(logic [7:0] o, logic [3:0] m);
        return (o == 8'h96) && (m == 4'h6);
    endfunction

    function automatic bit mode_bad(logic [3:0] m);
        return !(m == 4'h6 || m == 4'h9);
    endfunction

    // One cycle: check the registered alert, drive, check the combinational outputs, update the model.
    task automatic step(bit v, logic [31:0] d, bit p, logic [7:0] o, logic [3:0] m, string tag);
        bit acc, pop_ok;
        @(negedge clk);
        chk({tag, " R6 ovf_alert"}, 32'(ovf_alert), 32'(exp_ovf));
        in_valid = v; in_word = d; rd_pop = p; otp_ovr_en = o; obs_mode = m;
        #1;
        chk({tag, " R3 pass_valid"}, 32'(pass_valid), 32'(v));
        chk({tag, " R3 pass_word"}, pass_word, d);
        chk({tag, " R4 R8 rd_word"}, rd_word, (q.size() == 0) ? 32'h0 : q[0]);
        chk({tag, " R5 obs_full"}, 32'(obs_full), 32'(q.size() == DEPTH));
        chk({tag, " R5 obs_empty"}, 32'(obs_empty), 32'(q.size() == 0));
        chk({tag, " R9 mode_enc_err"}, 32'(mode_enc_err), 32'(mode_bad(m)));
        acc = v && cap_on(o, m) && !frozen && (q.size() < DEPTH);
        exp_ovf = v && cap_on(o, m) && !acc;
        pop_ok = p && (q.size() > 0);
        if (pop_ok) void'(q.pop_front());
        if (acc) q.push_back(d);
        if (acc && q.size() == DEPTH) frozen = 1;
        else if (pop_ok && q.size() == 0) frozen = 0;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 empty after reset", 32'(obs_empty), 32'h1);
        chk("R1 full after reset", 32'(obs_full), 32'h0);
        chk("R1 rd_word after reset", rd_word, 32'h0);
        chk("R1 ovf after reset", 32'(ovf_alert), 32'h0);

        // R2: no capture with a wrong enable or mode
        step(1, 32'hA1, 0, 8'h69, 4'h6, "R2 otp wrong");
        step(1, 32'hA2, 0, 8'h96, 4'h9, "R2 mode false");
        step(1, 32'hA3, 0, 8'h96, 4'h3, "R2 R9 mode illegal");
        step(0, 32'h0, 0, 8'h96, 4'h6, "R2 idle");
        chk("R2 still empty", 32'(obs_empty), 32'h1);
        // R8: pop on empty
        step(0, 32'h0, 1, 8'h96, 4'h6, "R8 empty pop");

        // R5: fill to 64
        for (int i = 0; i < DEPTH; i++)
            step(1, $urandom, 0, 8'h96, 4'h6, "R5 fill");
        // R6: drops while full
        step(1, 32'hDEAD, 0, 8'h96, 4'h6, "R6 drop1");
        step(1, 32'hBEEF, 0, 8'h96, 4'h6, "R6 drop2");
        // R7: partial pops do not re-arm
        for (int i = 0; i < 10; i++) step(0, 0, 1, 8'h96, 4'h6, "R7 partial pop");
        step(1, 32'h1111, 0, 8'h96, 4'h6, "R7 drop after partial");
        while (q.size() > 1) step(0, 0, 1, 8'h96, 4'h6, "R7 drain");
        step(1, 32'h2222, 1, 8'h96, 4'h6, "R7 last pop with word");
        step(1, 32'h3333, 0, 8'h96, 4'h6, "R7 first capture");
        step(0, 0, 0, 8'h96, 4'h6, "R7 settle");
        chk("R7 captured word", rd_word, 32'h3333);
        // R10: push and pop together
        step(1, 32'h4444, 1, 8'h96, 4'h6, "R10 push pop");
        step(0, 0, 0, 8'h96, 4'h6, "R10 settle");
        chk("R10 head after push pop", rd_word, 32'h4444);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 15);
            logic [3:0] m = (r < 12) ? 4'h6 : ((r < 14) ? 4'h9 : 4'($urandom));
            logic [7:0] o = (r == 15) ? 8'h00 : 8'h96;
            bit pp = ($urandom_range(0, 99) < ((i / 500) % 2 ? 70 : 25));
            step($urandom_range(0, 3) != 0, $urandom, pp, o, m, "RND");
        end
        step(0, 0, 0, 8'h96, 4'h6, "final");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule